// File: doc/BRIEF.md
# Dual-Clock Rewindable FIFO

This block carries words from a write clock domain into an independent read clock domain. The read side uses first-word-fall-through (FWFT): the oldest word waits on the data outputs with a ready indication, and each read enable pulse consumes it. Three occupancy flags report the fill level: almost-empty, half-full and almost-full. The almost-empty and almost-full thresholds are fixed at build time.

A retransmit request, sampled on the read clock, rewinds the read side to storage address 0. The whole stream written since reset can then be read out again. A retransmit gives a correct result only while no more than DEPTH words have been written since reset. A mode input chooses between two behaviours. In the rewind-with-gap mode the ready indication drops for a fixed number of read-clock edges. In the immediate mode the first word is reloaded on the request edge itself. Each occupancy flag settles after a rewind with its own latency, set by the clock domain it belongs to.

Top module: `fifo_rt`

## Requirements
- R1: While reset is asserted and after it is released, with nothing written: ready_o=0, full_o=0, pae_o=1, hf_o=0, paf_o=0.
- R2: FWFT. After a write, the word appears on rdata_o with ready_o=1 and no read enable. A read-clock edge with rd_en_i=1 and ready_o=1 consumes the word and shows the next word in write order. If no word is left, ready_o falls to 0.
- R3: full_o=1 while DEPTH words are held. A write while full_o=1 stores nothing and does not advance the write pointer.
- R4: A read enable while ready_o=0 consumes nothing, so the next word that arrives is still delivered.
- R5: With rt_zero_lat_i=0, a read-clock edge with rt_i=1 rewinds to address 0 and sets ready_o=0. ready_o stays 0 for RT_GAP edges and rd_en_i is ignored during that time. On the RT_GAP-th edge after the request, ready_o returns to 1 with the word from address 0 on rdata_o.
- R6: With rt_zero_lat_i=1, the read-clock edge with rt_i=1 loads the word from address 0 into rdata_o and sets ready_o=1 on that same edge.
- R7: After either kind of rewind, each read enable pulse delivers the next word in the original write order, starting from the second word.
- R8: hf_o=1 when more than DEPTH/2 words are unread, as seen by the read side. It is not registered, so a rewind changes it directly after the request edge.
- R9: pae_o=1 when the unread count is at most PAE_OFS. It is registered on the read clock and reflects a rewind from the second read-clock edge after the request.
- R10: paf_o=1 when the write side sees at least DEPTH-PAF_OFS words held. It reflects a rewind after the second write-clock edge that follows the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | DW | Write data |
| full_o | output | 1 | Storage full (write domain) |
| paf_o | output | 1 | Almost-full flag (write domain) |
| rd_en_i | input | 1 | Read enable, consumes the word on rdata_o |
| rt_i | input | 1 | Retransmit request (read domain) |
| rt_zero_lat_i | input | 1 | Retransmit mode: 1 immediate, 0 with setup gap |
| rdata_o | output | DW | FWFT output word |
| ready_o | output | 1 | rdata_o holds a valid word |
| pae_o | output | 1 | Almost-empty flag (read domain) |
| hf_o | output | 1 | Half-full flag (combinational from read-side state) |

## Verification
The bench drains the FIFO to two words and then rewinds it to fifteen, so that every flag must flip. Each flag is sampled on both sides of its stated edge. A half-full flag that was registered would lag one edge. An almost-empty flag with too few pipeline stages would flip on the first edge. An almost-full flag read through a single synchroniser stage would flip after the first write edge. Read enable is held high through the setup gap: a design that does not ignore it would come back with the second word in place of the first. An immediate-mode rewind on a drained FIFO, and writes past full followed by a full drain, catch a gap inserted where none belongs and an overwritten or duplicated word.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef enum logic {
    RD_RUN   = 1'b0,
    RD_SETUP = 1'b1
  } rd_state_e;
endpackage

// File: rtl/fifo_rt_sync.sv
// Two-flop Gray synchroniser with binary output.
module fifo_rt_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fifo_rt_wr.sv
module fifo_rt_wr #(
  parameter int AW      = 4,
  parameter int PAF_OFS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW:0]   cons_bin_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [AW:0]   ptr_o,
  output logic [AW:0]   gray_o,
  output logic          full_o,
  output logic          paf_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PAF_I = DEPTH - PAF_OFS;
  localparam int ONE_I = 1;
  localparam logic [AW:0] FULL_LVL = DEPTH[AW:0];
  localparam logic [AW:0] PAF_LVL  = PAF_I[AW:0];
  localparam logic [AW:0] PTR_ONE  = ONE_I[AW:0];

  logic [AW:0] ptr_q, ptr_d, gray_q, occ;

  assign occ    = ptr_q - cons_bin_i;
  assign full_o = occ >= FULL_LVL;
  assign paf_o  = occ >= PAF_LVL;
  assign we_o   = wr_en_i & ~full_o;
  assign ptr_d  = we_o ? ptr_q + PTR_ONE : ptr_q;
  assign addr_o = ptr_q[AW-1:0];
  assign ptr_o  = ptr_q;
  assign gray_o = gray_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      gray_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      gray_q <= ptr_d ^ (ptr_d >> 1);
    end
  end
endmodule

// File: rtl/fifo_rt_rd.sv
module fifo_rt_rd
  import fifo_rt_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 16,
  parameter int PAE_OFS = 2,
  parameter int RT_GAP  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          rt_i,
  input  logic          rt_zero_i,
  input  logic [AW:0]   wr_bin_i,
  input  logic [DW-1:0] mem_data_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW:0]   cons_ptr_o,
  output logic [AW:0]   cons_gray_o,
  output logic [DW-1:0] data_o,
  output logic          ready_o,
  output logic          busy_o,
  output logic          pae_o,
  output logic          hf_o
);
  localparam int DEPTH  = 1 << AW;
  localparam int HALF   = DEPTH / 2;
  localparam int CW     = $clog2(RT_GAP + 1);
  localparam int GAP_M1 = RT_GAP - 1;
  localparam int ONE_I  = 1;
  localparam logic [AW:0]   PTR_ONE  = ONE_I[AW:0];
  localparam logic [AW:0]   PAE_LVL  = PAE_OFS[AW:0];
  localparam logic [AW:0]   HALF_LVL = HALF[AW:0];
  localparam logic [CW-1:0] CNT_ONE  = ONE_I[CW-1:0];
  localparam logic [CW-1:0] GAP_LD   = GAP_M1[CW-1:0];

  rd_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW:0]   fetch_q, fetch_d;  // next address to load into the output register
  logic [AW:0]   cons_q, cons_d;    // words consumed by the reader
  logic [AW:0]   gray_q, occ_q, avail, occ_now;
  logic [DW-1:0] data_q, data_d;
  logic          ready_q, ready_d, pae_q, pop;

  assign avail      = wr_bin_i - fetch_q;
  assign occ_now    = wr_bin_i - cons_q;
  assign pop        = ready_q & rd_en_i & ~rt_i;
  assign mem_addr_o = rt_i ? '0 : fetch_q[AW-1:0];

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    fetch_d = fetch_q;
    cons_d  = cons_q;
    data_d  = data_q;
    ready_d = ready_q;
    if (rt_i) begin
      cons_d  = '0;
      fetch_d = '0;
      if (rt_zero_i) begin
        st_d = RD_RUN;
        if (wr_bin_i != '0) begin
          data_d  = mem_data_i;
          fetch_d = PTR_ONE;
          ready_d = 1'b1;
        end else begin
          ready_d = 1'b0;
        end
      end else begin
        st_d    = RD_SETUP;
        cnt_d   = GAP_LD;
        ready_d = 1'b0;
      end
    end else if (st_q == RD_SETUP) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_ONE;
      end else begin
        st_d = RD_RUN;
        if (avail != '0) begin
          data_d  = mem_data_i;
          fetch_d = fetch_q + PTR_ONE;
          ready_d = 1'b1;
        end
      end
    end else begin
      if (pop) cons_d = cons_q + PTR_ONE;
      if (!ready_q || pop) begin
        if (avail != '0) begin
          data_d  = mem_data_i;
          fetch_d = fetch_q + PTR_ONE;
          ready_d = 1'b1;
        end else begin
          ready_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RD_RUN;
      cnt_q   <= '0;
      fetch_q <= '0;
      cons_q  <= '0;
      gray_q  <= '0;
      data_q  <= '0;
      ready_q <= 1'b0;
      occ_q   <= '0;
      pae_q   <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      fetch_q <= fetch_d;
      cons_q  <= cons_d;
      gray_q  <= cons_d ^ (cons_d >> 1);
      data_q  <= data_d;
      ready_q <= ready_d;
      // two-stage path: pointer -> count -> flag
      occ_q   <= occ_now;
      pae_q   <= occ_q <= PAE_LVL;
    end
  end

  assign cons_ptr_o  = cons_q;
  assign cons_gray_o = gray_q;
  assign data_o      = data_q;
  assign ready_o     = ready_q;
  assign busy_o      = st_q == RD_SETUP;
  assign pae_o       = pae_q;
  assign hf_o        = occ_now > HALF_LVL;
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int DW      = 16,
  parameter int AW      = 4,
  parameter int PAE_OFS = 2,
  parameter int PAF_OFS = 2,
  parameter int RT_GAP  = 3
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic          full_o,
  output logic          paf_o,
  input  logic          rd_en_i,
  input  logic          rt_i,
  input  logic          rt_zero_lat_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  output logic          pae_o,
  output logic          hf_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] w_ptr, w_gray, w_bin_rs, r_cons, r_gray, r_cons_ws;
  logic [AW-1:0] w_addr, r_addr;
  logic [DW-1:0] r_mem;
  logic          w_we, r_busy;

  fifo_rt_wr #(.AW(AW), .PAF_OFS(PAF_OFS)) wr_i (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .cons_bin_i(r_cons_ws),
    .we_o(w_we), .addr_o(w_addr), .ptr_o(w_ptr), .gray_o(w_gray),
    .full_o(full_o), .paf_o(paf_o)
  );

  fifo_rt_mem #(.DW(DW), .AW(AW)) mem_i (
    .wclk_i(wclk_i), .we_i(w_we), .waddr_i(w_addr), .wdata_i(wdata_i),
    .raddr_i(r_addr), .rdata_o(r_mem)
  );

  fifo_rt_sync #(.W(PW)) w2r_i (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(w_gray), .bin_o(w_bin_rs)
  );

  fifo_rt_sync #(.W(PW)) r2w_i (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(r_gray), .bin_o(r_cons_ws)
  );

  fifo_rt_rd #(.AW(AW), .DW(DW), .PAE_OFS(PAE_OFS), .RT_GAP(RT_GAP)) rd_i (
    .clk_i(rclk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rt_i(rt_i),
    .rt_zero_i(rt_zero_lat_i), .wr_bin_i(w_bin_rs), .mem_data_i(r_mem),
    .mem_addr_o(r_addr), .cons_ptr_o(r_cons), .cons_gray_o(r_gray),
    .data_o(rdata_o), .ready_o(ready_o), .busy_o(r_busy),
    .pae_o(pae_o), .hf_o(hf_o)
  );
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int AW = 4
) (
  input logic        wclk_i,
  input logic        rclk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        full_i,
  input logic [AW:0] wptr_i,
  input logic        rd_en_i,
  input logic        rt_i,
  input logic        rt_zero_i,
  input logic        ready_i,
  input logic        busy_i,
  input logic [AW:0] cptr_i,
  input logic [AW:0] wbin_i
);
  localparam int ONE_I = 1;
  localparam logic [AW:0] PTR_ONE = ONE_I[AW:0];

  // R3
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_i && wr_en_i |=> $stable(wptr_i));

  // R4
  no_underflow_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !ready_i && rd_en_i && !rt_i |=> $stable(cptr_i));

  // R2
  pop_advance_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ready_i && rd_en_i && !rt_i |=> cptr_i == $past(cptr_i) + PTR_ONE);

  // R5
  rt_gap_drop_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rt_i && !rt_zero_i |=> !ready_i && cptr_i == '0);

  // R5
  setup_quiet_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    busy_i |-> !ready_i);

  // R6
  rt_zero_load_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rt_i && rt_zero_i && wbin_i != '0 |=> ready_i && cptr_i == '0);
endmodule

bind fifo_rt fifo_rt_chk #(.AW(AW)) chk_i (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
  .full_i(full_o), .wptr_i(w_ptr), .rd_en_i(rd_en_i), .rt_i(rt_i),
  .rt_zero_i(rt_zero_lat_i), .ready_i(ready_o), .busy_i(r_busy),
  .cptr_i(r_cons), .wbin_i(w_bin_rs)
);

// File: tb/fifo_rt_tb_top.sv
module fifo_rt_tb_top;
  localparam int DW = 16;
  localparam int AW = 4;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rt = 1'b0, rt_zero = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic full, paf, ready, pae, hf;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  initial forever #5 rclk = ~rclk;
  initial begin
    #2;
    forever #5 wclk = ~wclk;
  end

  fifo_rt #(.DW(DW), .AW(AW), .PAE_OFS(2), .PAF_OFS(2), .RT_GAP(3)) dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .full_o(full), .paf_o(paf), .rd_en_i(rd_en), .rt_i(rt), .rt_zero_lat_i(rt_zero),
    .rdata_o(rdata), .ready_o(ready), .pae_o(pae), .hf_o(hf)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic rstep(input int n);
    repeat (n) begin
      @(posedge rclk);
      @(negedge rclk);
    end
  endtask

  task automatic write_words(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en = 1'b1;
      wdata = base + DW'(i);
    end
    @(negedge wclk);
    wr_en = 1'b0;
    @(negedge rclk);
  endtask

  task automatic read_seq(input int n, input logic [DW-1:0] base, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      check({tag, " ready"}, 32'(ready), 32'd1);
      check({tag, " data"}, 32'(rdata), 32'(base + DW'(i)));
      rd_en = 1'b1;
    end
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    rstep(2);
    check("R1 ready in reset", 32'(ready), 32'd0);
    check("R1 pae in reset", 32'(pae), 32'd1);
    rst_n = 1'b1;
    rstep(4);
    check("R1 ready", 32'(ready), 32'd0);
    check("R1 full", 32'(full), 32'd0);
    check("R1 pae", 32'(pae), 32'd1);
    check("R1 hf", 32'(hf), 32'd0);
    check("R1 paf", 32'(paf), 32'd0);
  endtask

  task automatic t_fill();
    rd_en = 1'b1;
    rstep(3);
    rd_en = 1'b0;
    check("R4 empty read keeps ready low", 32'(ready), 32'd0);
    write_words(15, 16'hA000);
    rstep(8);
    check("R4 first word survives empty reads", 32'(rdata), 32'hA000);
    check("R2 fall-through ready", 32'(ready), 32'd1);
    check("R8 hf at 15", 32'(hf), 32'd1);
    check("R9 pae at 15", 32'(pae), 32'd0);
    check("R10 paf at 15", 32'(paf), 32'd1);
    check("R3 full at 15", 32'(full), 32'd0);
  endtask

  task automatic t_drain_part();
    read_seq(13, 16'hA000, "R2 in-order read");
    rstep(6);
    check("R2 next word", 32'(rdata), 32'hA00D);
    check("R9 pae at 2", 32'(pae), 32'd1);
    check("R8 hf at 2", 32'(hf), 32'd0);
    check("R10 paf at 2", 32'(paf), 32'd0);
  endtask

  task automatic t_rt_gap();
    @(negedge rclk);
    rt = 1'b1;
    rt_zero = 1'b0;
    @(posedge rclk);
    #1;
    check("R8 hf right after request edge", 32'(hf), 32'd1);
    check("R5 ready drops", 32'(ready), 32'd0);
    @(negedge rclk);
    rt = 1'b0;
    rd_en = 1'b1;                                   // must be ignored in setup
    check("R9 pae unchanged edge 0", 32'(pae), 32'd1);
    check("R10 paf unchanged after first wclk", 32'(paf), 32'd0);
    rstep(1);
    check("R5 ready low edge 1", 32'(ready), 32'd0);
    check("R9 pae unchanged edge 1", 32'(pae), 32'd1);
    check("R10 paf after second wclk", 32'(paf), 32'd1);
    rstep(1);
    rd_en = 1'b0;
    check("R5 ready low edge 2", 32'(ready), 32'd0);
    check("R9 pae updated edge 2", 32'(pae), 32'd0);
    rstep(1);
    check("R5 ready back edge 3", 32'(ready), 32'd1);
    check("R5 first word back", 32'(rdata), 32'hA000);
    read_seq(15, 16'hA000, "R7 replay");
    check("R2 drained ready low", 32'(ready), 32'd0);
  endtask

  task automatic t_rt_zero();
    rstep(4);
    check("R8 hf drained", 32'(hf), 32'd0);
    rt = 1'b1;
    rt_zero = 1'b1;
    @(negedge rclk);
    rt = 1'b0;
    rt_zero = 1'b0;
    check("R6 ready on request edge", 32'(ready), 32'd1);
    check("R6 word 0 on request edge", 32'(rdata), 32'hA000);
    check("R8 hf after immediate rewind", 32'(hf), 32'd1);
    check("R9 pae not yet", 32'(pae), 32'd1);
    read_seq(4, 16'hA000, "R7 immediate replay");
    check("R7 next after replay", 32'(rdata), 32'hA004);
  endtask

  task automatic t_overflow();
    rst_n = 1'b0;
    rstep(2);
    rst_n = 1'b1;
    rstep(2);
    write_words(20, 16'h0100);
    check("R3 full", 32'(full), 32'd1);
    check("R10 paf when full", 32'(paf), 32'd1);
    rstep(8);
    read_seq(16, 16'h0100, "R3 kept words");
    check("R3 no extra word", 32'(ready), 32'd0);
    rstep(6);
    check("R3 full cleared", 32'(full), 32'd0);
    check("R10 paf cleared", 32'(paf), 32'd0);
    check("R9 pae empty", 32'(pae), 32'd1);
  endtask

  initial begin
    @(negedge rclk);
    t_reset();
    t_fill();
    t_drain_part();
    t_rt_gap();
    t_rt_zero();
    t_overflow();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule